// File: doc/BRIEF.md
# Chip Select and Wait-State Decoder

This block sits beside a 68000-style bus master. It watches the 24-bit address, the 3-bit function code, the read/write line and the active-low address strobe. It drives four active-low chip selects, each with its own programmed window. For every window the block can also produce the data-transfer acknowledge after a fixed number of wait clocks. Alongside the acknowledge it reports whether the selected device is 8 or 16 bits wide, so that a byte-wide boot memory and a word-wide RAM can sit in one contiguous address map.

Each select has a 27-bit setup word, loaded through a simple write port. A separate mode bit turns select 2 into four 16 KB peripheral selects laid end to end at the bottom of its window. The decode is captured on the first clock edge that sees the address strobe low. Everything releases at once when the strobe rises.

Top module: `cs_wait_decoder`

## Requirements
- R1: A setup word is laid out as follows: base in bits 11:0, size code n in bits 15:12, direction in 17:16, match-any-function-code in 18, function code in 21:19, acknowledge enable in 22, wait count in 25:23, 16-bit width in 26. A write with `cfg_idx` 0 to 3 loads that select's word. Select i matches when address bits 23:12+n equal the same bits of its base, so the block is 4 KB shifted left by n, and a code of 12 or more matches everything.
- R2: The direction field gates the select. Value 01 allows reads only (`rw`=1), 10 allows writes only, 11 allows both and 00 allows neither. An access in a disallowed direction asserts no select.
- R3: When bit 18 is clear, a select matches only if `fc` equals its programmed code. When bit 18 is set, any `fc` value matches.
- R4: If several selects match, only the lowest-numbered one is asserted. At most one of `cs_n` and `pcs_n` is low at any time.
- R5: With acknowledge enabled and wait count W, `dtack_n` goes low W clocks after the select first goes low and stays low until the strobe rises. W=0 means it goes low together with the select, and a field value of 7 acts as 6.
- R6: With acknowledge disabled, `dtack_n` stays high for that select for the whole cycle.
- R7: A write with `cfg_idx`=4 sets the split mode from `cfg_data[0]`. In split mode, select 2 drives `pcs_n[k]` instead of `cs_n[2]`, where k is the 16 KB block index within the first 64 KB of its window. Addresses beyond those 64 KB do not match select 2.
- R8: `port16` is high while a select whose width bit is set is asserted. It is low otherwise.
- R9: The select goes low one clock edge after the strobe is first sampled low. The outputs return high as soon as `as_n` is high, and the wait count starts again from zero in the next cycle.
- R10: After reset, every setup word and the split mode are zero, so no select and no acknowledge are ever asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| addr | input | 24 | Bus address |
| fc | input | 3 | Function code |
| rw | input | 1 | 1 = read, 0 = write |
| cfg_we | input | 1 | Setup write strobe |
| cfg_idx | input | 3 | 0..3 select word, 4 split mode |
| cfg_data | input | 27 | Setup word |
| cs_n | output | 4 | Chip selects, active low |
| pcs_n | output | 4 | Peripheral selects carved from select 2, active low |
| dtack_n | output | 1 | Self-timed acknowledge, active low |
| port16 | output | 1 | Selected device is 16 bits wide |

## Verification
The windows are laid out so that two of them overlap. One address then hits both, one hits only the higher-numbered select, and one falls outside every window. This separates a wrong priority from a wrong range mask. The same addresses are repeated with the opposite direction and with a wrong function code, which shows that a match is refused by qualification rather than by range. The acknowledge is sampled on the clock just before and the clock of its expected edge for wait counts of 0, 2 and 7. Two cycles run back to back to show that the count restarts. Split mode is tried on two peripheral blocks and on an address just past the first 64 KB.

// File: rtl/cs_wait_decoder.sv
module cs_wait_decoder #(
  parameter int ADDR_W = 24,
  parameter int BASE_W = 12,
  parameter int PBLK_LOG2 = 14,
  parameter int WAIT_W = 3,
  parameter int WAIT_MAX = 6,
  localparam int CFG_W = BASE_W + 12 + WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        fc,
  input  logic              rw,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic [3:0]        cs_n,
  output logic [3:0]        pcs_n,
  output logic              dtack_n,
  output logic              port16
);
  localparam int PAGE_LSB = ADDR_W - BASE_W;
  localparam int F_SIZE = BASE_W;
  localparam int F_DIR = BASE_W + 4;
  localparam int F_FCALL = BASE_W + 6;
  localparam int F_FCV = BASE_W + 7;
  localparam int F_ACK = BASE_W + 10;
  localparam int F_WAIT = BASE_W + 11;
  localparam int F_W16 = BASE_W + 11 + WAIT_W;
  localparam int BLK_LSB = PBLK_LOG2 - PAGE_LSB;

  logic [CFG_W-1:0]  cfg_q [4];
  logic              split_q;
  logic              active_q;
  logic [3:0]        win_q;
  logic              spl_q;
  logic [1:0]        blk_q;
  logic              ack_q;
  logic              w16_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] cnt_q;

  logic [BASE_W-1:0] addr_hi;
  logic [BASE_W-1:0] off2;
  logic [3:0]        hit;
  logic [3:0]        win;
  logic [CFG_W-1:0]  wcfg;
  logic [WAIT_W-1:0] wfield;
  logic              live;

  assign addr_hi = addr[ADDR_W-1:PAGE_LSB];
  assign off2 = addr_hi - cfg_q[2][BASE_W-1:0];

  genvar i;
  for (i = 0; i < 4; i++) begin : g_sel
    logic [BASE_W-1:0] hi_mask;
    logic in_rng, dir_ok, fc_ok, blk_ok;
    assign hi_mask = {BASE_W{1'b1}} << cfg_q[i][F_SIZE +: 4];
    assign in_rng = ((addr_hi ^ cfg_q[i][BASE_W-1:0]) & hi_mask) == '0;
    assign dir_ok = rw ? cfg_q[i][F_DIR] : cfg_q[i][F_DIR+1];
    assign fc_ok = cfg_q[i][F_FCALL] | (fc == cfg_q[i][F_FCV +: 3]);
    if (i == 2) begin : g_split
      assign blk_ok = ~split_q | (off2[BASE_W-1:BLK_LSB+2] == '0);
    end else begin : g_plain
      assign blk_ok = 1'b1;
    end
    assign hit[i] = in_rng & dir_ok & fc_ok & blk_ok;
  end

  assign win = hit & (~hit + 4'd1);

  always_comb begin
    wcfg = '0;
    for (int j = 0; j < 4; j++)
      if (win[j]) wcfg = cfg_q[j];
  end

  assign wfield = wcfg[F_WAIT +: WAIT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 4; j++) cfg_q[j] <= '0;
      split_q  <= 1'b0;
      active_q <= 1'b0;
      win_q    <= '0;
      spl_q    <= 1'b0;
      blk_q    <= '0;
      ack_q    <= 1'b0;
      w16_q    <= 1'b0;
      wait_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_idx < 3'd4) cfg_q[cfg_idx[1:0]] <= cfg_data;
        else if (cfg_idx == 3'd4) split_q <= cfg_data[0];
      end
      if (as_n) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (!active_q) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        win_q    <= win;
        spl_q    <= split_q;
        blk_q    <= off2[BLK_LSB +: 2];
        ack_q    <= wcfg[F_ACK];
        w16_q    <= wcfg[F_W16];
        wait_q   <= (wfield > WAIT_W'(WAIT_MAX)) ? WAIT_W'(WAIT_MAX) : wfield;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign live = active_q & ~as_n;
  assign cs_n = ~(win_q & {4{live}} & {1'b1, ~spl_q, 2'b11});
  assign pcs_n = ~({4{live & win_q[2] & spl_q}} & (4'd1 << blk_q));
  assign dtack_n = ~(live & (|win_q) & ack_q & (cnt_q >= wait_q));
  assign port16 = live & (|win_q) & w16_q;

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~cs_n, ~pcs_n}));

  assert_strobe_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (&cs_n && &pcs_n && dtack_n && !port16));

  assert_ack_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !(&cs_n && &pcs_n));

  assert_ack_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !as_n) |=> (as_n || !dtack_n));

  assert_select_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !as_n) |=> (as_n || $stable({cs_n, pcs_n, port16})));

  assert_split_hides_cs2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&pcs_n) |-> (cs_n[2] && win_q[2]));
endmodule

// File: tb/test_cs_wait_decoder.sv
module test_cs_wait_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, as_n = 1'b1, rw = 1'b1, cfg_we = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0] fc = '0, cfg_idx = '0;
  logic [26:0] cfg_data = '0;
  logic [3:0] cs_n, pcs_n;
  logic dtack_n, port16;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [9:0] exp_q[$];
  string tag_q[$];

  cs_wait_decoder i_cs_wait_decoder (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .fc(fc), .rw(rw),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cs_n(cs_n), .pcs_n(pcs_n), .dtack_n(dtack_n), .port16(port16));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [26:0] mk(input logic [11:0] base, input logic [3:0] size,
      input logic [1:0] dir, input logic fcall, input logic [2:0] fcv,
      input logic ack, input logic [2:0] w, input logic w16);
    return {w16, w, ack, fcv, fcall, dir, size, base};
  endfunction

  task automatic cfg_write(input logic [2:0] idx, input logic [26:0] d);
    @(negedge clk);
    cfg_idx = idx; cfg_data = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [3:0] ecs, input logic [3:0] epcs, input logic ack,
      input logic p16, input string tag);
    exp_q.push_back({~ecs, ~epcs, ~ack, p16});
    tag_q.push_back(tag);
  endtask

  task automatic bus_cycle(input logic [23:0] a, input logic [2:0] f, input logic r,
      input int nclk, input logic [3:0] ecs, input logic [3:0] epcs, input int w,
      input logic p16, input string tag);
    @(negedge clk);
    addr = a; fc = f; rw = r; as_n = 1'b0;
    push(4'h0, 4'h0, 1'b0, 1'b0, tag);
    for (int k = 1; k <= nclk; k++) begin
      @(negedge clk);
      push(ecs, epcs, (w >= 0) && (k - 1 >= w) && ((ecs | epcs) != 0),
           p16 && ((ecs | epcs) != 0), tag);
    end
    @(negedge clk);
    as_n = 1'b1;
    push(4'h0, 4'h0, 1'b0, 1'b0, {tag, " release"});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) begin
        logic [9:0] e;
        logic [9:0] act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = {cs_n, pcs_n, dtack_n, port16};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s: cs_n/pcs_n/dtack_n/port16 actual %b expected %b", t, act, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_cycle(24'h001234, 3'd5, 1'b1, 3, 4'h0, 4'h0, -1, 1'b0, "R10 reset state");

    cfg_write(3'd0, mk(12'h000, 4'd4, 2'b11, 1'b1, 3'd0, 1'b1, 3'd0, 1'b0));
    cfg_write(3'd1, mk(12'h100, 4'd8, 2'b01, 1'b1, 3'd0, 1'b1, 3'd2, 1'b1));
    cfg_write(3'd2, mk(12'h200, 4'd6, 2'b11, 1'b0, 3'd5, 1'b1, 3'd7, 1'b0));
    cfg_write(3'd3, mk(12'h000, 4'd5, 2'b10, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1));

    bus_cycle(24'h001234, 3'd2, 1'b1, 3, 4'b0001, 4'h0, 0, 1'b0, "R1 R8 cs0 8-bit wait0");
    bus_cycle(24'h008000, 3'd1, 1'b0, 3, 4'b0001, 4'h0, 0, 1'b0, "R4 overlap cs0 wins");
    bus_cycle(24'h018000, 3'd1, 1'b0, 4, 4'b1000, 4'h0, -1, 1'b1, "R6 cs3 no ack");
    bus_cycle(24'h018000, 3'd1, 1'b1, 3, 4'h0, 4'h0, -1, 1'b0, "R2 write-only read");
    bus_cycle(24'h1ABCDE, 3'd6, 1'b1, 5, 4'b0010, 4'h0, 2, 1'b1, "R5 cs1 wait2");
    bus_cycle(24'h1ABCDE, 3'd6, 1'b1, 5, 4'b0010, 4'h0, 2, 1'b1, "R9 count restart");
    bus_cycle(24'h1ABCDE, 3'd6, 1'b0, 3, 4'h0, 4'h0, -1, 1'b0, "R2 read-only write");
    bus_cycle(24'h300000, 3'd5, 1'b1, 3, 4'h0, 4'h0, -1, 1'b0, "R1 outside windows");
    bus_cycle(24'h204000, 3'd5, 1'b1, 9, 4'b0100, 4'h0, 6, 1'b0, "R5 R3 wait7 as 6");
    bus_cycle(24'h204000, 3'd1, 1'b1, 3, 4'h0, 4'h0, -1, 1'b0, "R3 fc mismatch");

    cfg_write(3'd4, 27'd1);
    bus_cycle(24'h20C000, 3'd5, 1'b1, 3, 4'h0, 4'b1000, 6, 1'b0, "R7 peripheral block 3");
    bus_cycle(24'h204000, 3'd5, 1'b0, 8, 4'h0, 4'b0010, 6, 1'b0, "R7 peripheral block 1");
    bus_cycle(24'h210000, 3'd5, 1'b1, 3, 4'h0, 4'h0, -1, 1'b0, "R7 past 64KB");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule